// File: doc/BRIEF.md
# GPIO input debouncer

This block cleans up one asynchronous general-purpose input before it reaches the pin-status bit and the interrupt logic downstream. The raw pin is first brought into the system clock domain by a short synchronizer chain. The synchronized level is then compared against the debounced output. A new level is only accepted once it has stayed put for a programmed window. The window is measured in strobes of a slow reference clock, nominally 32.768 kHz, which reaches the block as a one-cycle clock-enable pulse in the system clock domain.

The window is the product of a 4-bit timer count and a tick length. Two range bits select the tick length. In the slowest range the window reaches about one second; in the fastest it stays under a millisecond.

A 2-bit filter type decides which transitions are debounced:
- Both directions.
- Rising only, so short low pulses still pass.
- Falling only, so short high pulses still pass.
- None, so the synchronized pin goes straight through.

Software programs the configuration while the input is idle.

Top module: `gpio_debounce`

## Requirements
- R1: While reset is asserted, and directly after it is released, `pin_level` is 0.
- R2: With `cfg_mode` = 2'b00 (off), `pin_level` follows `pin_raw` after the synchronizer and one output register, whatever the timer count. A single-cycle pulse on `pin_raw` is reproduced at the output.
- R3: With `cfg_mode` = 2'b11 (both directions filtered), a rising level is accepted at the W-th slow strobe counted while the synchronized input differs from the output. W is `cfg_count` times the tick length.
- R4: With `cfg_mode` = 2'b11, a falling level obeys the same W-strobe rule as R3.
- R5: The tick length is selected by {`cfg_large`, `cfg_unit`}: 2'b00 gives 2 strobes, 2'b01 gives 8, 2'b10 gives 512 and 2'b11 gives 2048.
- R6: A filtered excursion that returns to the output level before W strobes have been counted never reaches `pin_level`. The strobe count restarts from zero for the next excursion.
- R7: With `cfg_mode` = 2'b01, rising changes are debounced as in R3, while falling changes pass as in R2.
- R8: With `cfg_mode` = 2'b10, falling changes are debounced as in R4, while rising changes pass as in R2.
- R9: A `cfg_count` of zero makes every filter type behave as pass-through.
- R10: When both directions are filtered and the count is non-zero, `pin_level` changes only on a clock edge at which `slow_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_en | input | 1 | One-cycle strobe per slow reference clock period |
| pin_raw | input | 1 | Asynchronous raw pin level |
| cfg_mode | input | 2 | Filter type: 00 off, 01 debounce rising only, 10 debounce falling only, 11 debounce both |
| cfg_count | input | 4 | Number of ticks in the debounce window |
| cfg_large | input | 1 | Range select, upper bit of the tick-length code |
| cfg_unit | input | 1 | Range select, lower bit of the tick-length code |
| pin_level | output | 1 | Debounced pin level |

## Verification
Let n be the clock edge before a new level is driven on `pin_raw`. A pass-through change then appears at the output at edge n+3: two synchronizer flops, then the output register. A debounced change appears at the W-th strobe edge at or after n+3.

The driver computes this due edge from the configuration and its own strobe schedule, and queues it together with the expected level. The monitor samples on the falling clock edge and, at every output change, pops the queue and compares both the level and the edge number. Any change arriving with an empty queue is counted as an error. Glitch windows are sized to hold one strobe fewer than W, so a filter that fires early, or fails to restart, shows up as an unexpected change.

// File: rtl/dbn_pkg.sv
package dbn_pkg;

  typedef enum logic [1:0] {
    FLT_OFF       = 2'b00,
    FLT_KEEP_LOW  = 2'b01,
    FLT_KEEP_HIGH = 2'b10,
    FLT_BOTH      = 2'b11
  } flt_mode_e;

  // Is a transition toward level 'rising' subject to the debounce window?
  function automatic logic dir_filtered(flt_mode_e mode, logic rising);
    logic f;
    case (mode)
      FLT_KEEP_LOW:  f = rising;
      FLT_KEEP_HIGH: f = ~rising;
      FLT_BOTH:      f = 1'b1;
      default:       f = 1'b0;
    endcase
    return f;
  endfunction

  // log2 of the tick length for the two range-select bits
  function automatic int unsigned range_log2(logic [1:0] sel, int unsigned l0,
                                             int unsigned l1, int unsigned l2,
                                             int unsigned l3);
    int unsigned r;
    case (sel)
      2'b00:   r = l0;
      2'b01:   r = l1;
      2'b10:   r = l2;
      default: r = l3;
    endcase
    return r;
  endfunction

  function automatic int unsigned max_of4(int unsigned a, int unsigned b,
                                          int unsigned c, int unsigned d);
    int unsigned m;
    m = 1;
    if (a > m) m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/dbn_sync.sv
module dbn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  localparam int NS = (STAGES < 2) ? 2 : STAGES;

  logic [NS-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[NS-2:0], d_async};
  end

  assign d_sync = chain_q[NS-1];
endmodule

// File: rtl/dbn_prescale.sv
module dbn_prescale import dbn_pkg::*; #(
  parameter int unsigned RNG0_LOG2 = 1,
  parameter int unsigned RNG1_LOG2 = 3,
  parameter int unsigned RNG2_LOG2 = 9,
  parameter int unsigned RNG3_LOG2 = 11,
  parameter int unsigned PRE_W     = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       slow_en,
  input  logic [1:0] range_sel,
  output logic       tick
);
  logic [PRE_W-1:0] presc_q;
  logic [PRE_W-1:0] limit;
  logic             at_limit;

  always_comb begin
    limit = PRE_W'((32'd1 << range_log2(range_sel, RNG0_LOG2, RNG1_LOG2,
                                        RNG2_LOG2, RNG3_LOG2)) - 32'd1);
  end

  assign at_limit = (presc_q == limit);
  assign tick     = run & slow_en & at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       presc_q <= '0;
    else if (!run)    presc_q <= '0;
    else if (slow_en) presc_q <= at_limit ? '0 : presc_q + 1'b1;
  end
endmodule

// File: rtl/dbn_stable.sv
module dbn_stable #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] count,
  output logic             done
);
  logic [CNT_W-1:0] ticks_q;
  logic             last_tick;

  assign last_tick = (ticks_q == (count - CNT_W'(1)));
  assign done      = run & tick & last_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             ticks_q <= '0;
    else if (!run || done)  ticks_q <= '0;
    else if (tick)          ticks_q <= ticks_q + 1'b1;
  end
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce import dbn_pkg::*; #(
  parameter int          CNT_W       = 4,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned RNG0_LOG2   = 1,
  parameter int unsigned RNG1_LOG2   = 3,
  parameter int unsigned RNG2_LOG2   = 9,
  parameter int unsigned RNG3_LOG2   = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_en,
  input  logic             pin_raw,
  input  logic [1:0]       cfg_mode,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             cfg_large,
  input  logic             cfg_unit,
  output logic             pin_level
);
  localparam int unsigned PRE_W = max_of4(RNG0_LOG2, RNG1_LOG2, RNG2_LOG2, RNG3_LOG2);

  flt_mode_e mode;
  logic      sync_lvl;   // synchronized pin
  logic      pending;    // synchronized pin disagrees with output
  logic      filt;       // this transition must wait out the window
  logic      run;        // window counters active
  logic      tick;       // one tick of the selected range elapsed
  logic      win_done;   // full window elapsed
  logic      level_q;

  assign mode = flt_mode_e'(cfg_mode);

  dbn_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(pin_raw),
    .d_sync (sync_lvl)
  );

  assign pending = sync_lvl ^ level_q;

  always_comb begin
    filt = dir_filtered(mode, sync_lvl) && (cfg_count != '0);
  end

  assign run = pending & filt;

  dbn_prescale #(
    .RNG0_LOG2(RNG0_LOG2), .RNG1_LOG2(RNG1_LOG2),
    .RNG2_LOG2(RNG2_LOG2), .RNG3_LOG2(RNG3_LOG2),
    .PRE_W    (PRE_W)
  ) i_prescale (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .slow_en  (slow_en),
    .range_sel({cfg_large, cfg_unit}),
    .tick     (tick)
  );

  dbn_stable #(.CNT_W(CNT_W)) i_stable (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick),
    .count(cfg_count),
    .done (win_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          level_q <= 1'b0;
    else if (pending && (!filt || win_done)) level_q <= sync_lvl;
  end

  assign pin_level = level_q;
endmodule

// File: rtl/dbn_checker.sv
module dbn_checker #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slow_en,
  input logic [1:0]       cfg_mode,
  input logic [CNT_W-1:0] cfg_count,
  input logic             sync_lvl,
  input logic             pin_level
);
  a_r1_reset_low: assert property (@(posedge clk) !rst_n |-> !pin_level)
    else $error("R1: output high during reset");

  a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'b00) |=> (pin_level == $past(sync_lvl)))
    else $error("R2: pass-through did not follow synchronized input");

  a_r6_hold_when_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_lvl == pin_level) |=> $stable(pin_level))
    else $error("R6: output moved while input agreed");

  a_r7_fall_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'b01 && !sync_lvl && pin_level) |=> !pin_level)
    else $error("R7: falling edge not passed at once");

  a_r8_rise_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'b10 && sync_lvl && !pin_level) |=> pin_level)
    else $error("R8: rising edge not passed at once");

  a_r10_change_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pin_level) && $past(cfg_mode == 2'b11 && cfg_count != '0))
      |-> $past(slow_en))
    else $error("R10: filtered change off a strobe");
endmodule

bind gpio_debounce dbn_checker #(.CNT_W(CNT_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .slow_en  (slow_en),
  .cfg_mode (cfg_mode),
  .cfg_count(cfg_count),
  .sync_lvl (sync_lvl),
  .pin_level(pin_level)
);

// File: tb/test_gpio_debounce.sv
module test_gpio_debounce;
  localparam int CLK_PERIOD = 10;
  localparam int STROBE_DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_en = 1'b0;
  logic       pin_raw = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic [3:0] cfg_count = 4'd0;
  logic       cfg_large = 1'b0;
  logic       cfg_unit = 1'b0;
  logic       pin_level;

  gpio_debounce i_gpio_debounce (
    .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .pin_raw(pin_raw),
    .cfg_mode(cfg_mode), .cfg_count(cfg_count), .cfg_large(cfg_large),
    .cfg_unit(cfg_unit), .pin_level(pin_level)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;   // number of rising edges so far
  always @(posedge clk) cyc = cyc + 1;

  // strobe is high at exactly those edges whose number is a multiple of STROBE_DIV
  always @(negedge clk) slow_en <= (((cyc + 1) % STROBE_DIV) == 0);

  typedef struct { logic v; int due; string req; } exp_t;
  exp_t q[$];

  int   checks = 0;
  int   errors = 0;
  logic lvl = 1'b0;    // modelled output level
  logic seen = 1'b0;
  bit   mon_en = 1'b0;
  bit   done = 1'b0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int tick_len();
    case ({cfg_large, cfg_unit})
      2'b00:   return 2;
      2'b01:   return 8;
      2'b10:   return 512;
      default: return 2048;
    endcase
  endfunction

  function automatic bit immediate(bit rising);
    if (cfg_count == 0) return 1;
    if (cfg_mode == 2'b00) return 1;
    if (cfg_mode == 2'b01) return !rising;
    if (cfg_mode == 2'b10) return rising;
    return 0;
  endfunction

  function automatic int due_edge(int n, bit rising);
    int first;
    if (immediate(rising)) return n + 3;
    first = ((n + 3 + STROBE_DIV - 1) / STROBE_DIV) * STROBE_DIV;
    return first + (int'(cfg_count) * tick_len() - 1) * STROBE_DIV;
  endfunction

  task automatic set_cfg(logic [1:0] m, logic [3:0] c, logic lg, logic un);
    @(negedge clk);
    cfg_mode = m; cfg_count = c; cfg_large = lg; cfg_unit = un;
  endtask

  task automatic step(logic v, string req);
    exp_t e;
    @(negedge clk);
    pin_raw = v;
    e.v = v; e.due = due_edge(cyc, v); e.req = req;
    q.push_back(e);
    lvl = v;
    while (cyc < e.due + 2) @(negedge clk);
  endtask

  task automatic pulse_through(logic v, string req);
    exp_t e;
    @(negedge clk);
    pin_raw = v;
    e.v = v; e.due = cyc + 3; e.req = req; q.push_back(e);
    @(negedge clk);
    pin_raw = lvl;
    e.v = lvl; e.due = cyc + 3; e.req = req; q.push_back(e);
    repeat (6) @(negedge clk);
  endtask

  // excursion spanning one strobe fewer than the window
  task automatic glitch(logic v, string req);
    int len;
    len = (int'(cfg_count) * tick_len() - 1) * STROBE_DIV;
    @(negedge clk);
    pin_raw = v;
    repeat (len) @(negedge clk);
    pin_raw = lvl;
    repeat (8) @(negedge clk);
    check(pin_level == lvl, req, "glitch reached output", pin_level, lvl);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_en && pin_level !== seen) begin
      seen = pin_level;
      if (q.size() == 0) begin
        check(0, "R6", "unexpected output change", pin_level, !pin_level);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(pin_level == e.v, e.req, "level", pin_level, e.v);
        check(cyc == e.due, e.req, "edge of change", cyc, e.due);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      check(0, "R1", "watchdog expired", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pin_level == 1'b0, "R1", "level in reset", pin_level, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pin_level == 1'b0, "R1", "level after reset", pin_level, 0);
    mon_en = 1'b1;

    // R2: pass-through
    set_cfg(2'b00, 4'd5, 1'b0, 1'b0);
    step(1'b1, "R2");
    pulse_through(1'b0, "R2");

    // R3/R4: both directions, range 00, count 3
    set_cfg(2'b11, 4'd3, 1'b0, 1'b0);
    step(1'b0, "R4");
    step(1'b1, "R3");
    // R6: short low excursion, then a real fall timed from its own start
    glitch(1'b0, "R6");
    step(1'b0, "R6");

    // R5: remaining ranges
    set_cfg(2'b11, 4'd2, 1'b0, 1'b1);
    step(1'b1, "R5");
    set_cfg(2'b11, 4'd1, 1'b1, 1'b0);
    step(1'b0, "R5");
    set_cfg(2'b11, 4'd1, 1'b1, 1'b1);
    step(1'b1, "R5");

    // R7: rising debounced, falling immediate
    set_cfg(2'b01, 4'd2, 1'b0, 1'b0);
    step(1'b0, "R7");
    glitch(1'b1, "R7");
    step(1'b1, "R7");

    // R8: falling debounced, rising immediate
    set_cfg(2'b10, 4'd2, 1'b0, 1'b0);
    glitch(1'b0, "R8");
    step(1'b0, "R8");
    step(1'b1, "R8");

    // R9: zero count passes through
    set_cfg(2'b11, 4'd0, 1'b1, 1'b1);
    step(1'b0, "R9");
    step(1'b1, "R9");

    repeat (10) @(negedge clk);
    check(q.size() == 0, "R10", "expected changes never seen", q.size(), 0);
    check(pin_level == lvl, "R10", "final level", pin_level, lvl);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule